// File: doc/BRIEF.md
# Serial Boot Loader Sequencer

This block is the hardware sequencer that runs the serial start-up after a reset into boot mode. It sits between a byte-wide UART and a 256-byte RAM write port. When the secure flag is set, it first clears protected content: it sends a $FF byte and asks for a non-volatile erase. If an erase fails, it sends $FF again and retries. Once an erase succeeds, it fills the RAM with $FF and then erases the configuration word. After that, or right away when the flag is clear, it sends a break to show that it is ready.

The first character from the host then picks what happens next. $FF starts a download. Every later byte is written to RAM from address 0 upward and sent back as an echo. After the last byte, control passes to the RAM base. $55 passes control to the RAM base at once, with no download. $00 or a line break passes control to the non-volatile base at $B600.

Two code points choose the link speed. $FF received at the fast rate keeps the fast divider. The byte pattern $E0, which is what a $FF sent at the slow rate looks like when sampled at the fast rate, switches the UART to the slow divider for good. The UART and the erase timing are outside this block.

Top module: `boot_seq`

## Requirements
- R1: While reset is held, tx_valid, erase_req, ram_we, done and rate_slow are all 0.
- R2: With sec_bit=1, the block first sends the byte $FF and then raises erase_req with erase_sel=0. When erase_done arrives with erase_ok=0, it sends $FF again and repeats the erase.
- R3: After an erase that reports erase_ok=1, the block writes $FF to RAM addresses 0 to 255 in ascending order. It then raises erase_req with erase_sel=1 and waits for erase_done.
- R4: When the security steps are complete, or when sec_bit=0, the block sends one break (tx_break=1). Only after that does it accept a command character.
- R5: A first character of $FF starts a download at the fast rate. That character is neither written to RAM nor echoed.
- R6: During a download, the k-th byte received is written to RAM address k and echoed once. After the echo of the byte for address 255 is accepted, done pulses with jump_addr=$0000.
- R7: A first character of $55 pulses done with jump_addr=$0000 and writes nothing to RAM.
- R8: A first character of $00 or an rx_break pulses done with jump_addr=$B600. When rx_break and rx_valid arrive in the same cycle, the break wins.
- R9: A first character of $E0 sets rate_slow=1, which then stays set, and starts a download in the same way as R5.
- R10: Any other first character is ignored: no transmit, no RAM write and no done. The block keeps waiting for a valid command.
- R11: A raised tx_valid or erase_req holds steady with unchanged data, break flag and erase selector until tx_ready or erase_done.
- R12: done is a single-cycle pulse and occurs once per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_bit | input | 1 | Secure flag, sampled on leaving reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line break detected |
| tx_ready | input | 1 | UART accepts the transmit request this cycle |
| tx_valid | output | 1 | Transmit request |
| tx_data | output | 8 | Byte to transmit |
| tx_break | output | 1 | Request is a break, not a byte |
| rate_slow | output | 1 | Select the slow baud divider |
| erase_done | input | 1 | Erase finished (one-cycle pulse) |
| erase_ok | input | 1 | Erase result, valid with erase_done |
| erase_req | output | 1 | Erase request |
| erase_sel | output | 1 | 0 = non-volatile array, 1 = configuration word |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| done | output | 1 | Hand-over pulse |
| jump_addr | output | 16 | Hand-over target address |

## Verification
Most faults in the sequencer show up at the ports within the next transmit or write.

- **State order.** A wrong state order changes the sequence of transmitted items: $FF bytes, then one break, then the echoes. It also changes the number of erase requests of each kind.
- **Address counter.** A counter fault shows up on the first write that is out of order, and again in the RAM image left after the fill or the download.
- **Command decoding.** A decoding fault shows up within a few cycles of the first character, as the wrong jump target, a wrong rate select, or an action taken on a byte that should have been ignored.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CH_LOAD   = 8'hFF;
  localparam logic [BYTE_W-1:0] CH_RUNRAM = 8'h55;
  localparam logic [BYTE_W-1:0] CH_RUNEE  = 8'h00;
  localparam logic [BYTE_W-1:0] CH_FILL   = 8'hFF;
  localparam logic [BYTE_W-1:0] CH_SECURE = 8'hFF;

  typedef enum logic [3:0] {
    ST_START,
    ST_SEC_TX,
    ST_SEC_ERASE,
    ST_SEC_FILL,
    ST_SEC_CFG,
    ST_ANNOUNCE,
    ST_CMD,
    ST_LOAD,
    ST_ECHO,
    ST_JUMP,
    ST_HALT
  } boot_state_t;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LOAD_FAST,
    CMD_LOAD_SLOW,
    CMD_RUN_RAM,
    CMD_RUN_EE
  } cmd_kind_t;

  // First-character classification; a line break outranks any byte.
  function automatic cmd_kind_t classify_first(
    input logic              brk,
    input logic              vld,
    input logic [BYTE_W-1:0] b,
    input logic [BYTE_W-1:0] slow_code
  );
    if (brk)             return CMD_RUN_EE;
    if (!vld)            return CMD_NONE;
    if (b == CH_LOAD)    return CMD_LOAD_FAST;
    if (b == slow_code)  return CMD_LOAD_SLOW;
    if (b == CH_RUNRAM)  return CMD_RUN_RAM;
    if (b == CH_RUNEE)   return CMD_RUN_EE;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/boot_cmd_decode.sv
module boot_cmd_decode
  import boot_seq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SLOW_CODE = 8'hE0
) (
  input  logic              enable,
  input  logic              rx_break,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output cmd_kind_t         kind
);

  always_comb begin
    if (enable) kind = classify_first(rx_break, rx_valid, rx_data, SLOW_CODE);
    else        kind = CMD_NONE;
  end

endmodule

// File: rtl/boot_addr_ctr.sv
module boot_addr_ctr #(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          at_last
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign at_last = (addr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)   addr <= '0;
    else if (inc) addr <= at_last ? '0 : addr + 1'b1;
  end

endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int                RAM_DEPTH = 256,
  parameter int                JUMP_W    = 16,
  parameter logic [JUMP_W-1:0] RAM_BASE  = 16'h0000,
  parameter logic [JUMP_W-1:0] EE_BASE   = 16'hB600,
  parameter logic [BYTE_W-1:0] SLOW_CODE = 8'hE0,
  localparam int AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_bit,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_break,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_break,
  output logic              rate_slow,
  input  logic              erase_done,
  input  logic              erase_ok,
  output logic              erase_req,
  output logic              erase_sel,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              done,
  output logic [JUMP_W-1:0] jump_addr
);

  boot_state_t       state_q, state_d;
  logic [BYTE_W-1:0] echo_q;
  logic              last_q;
  logic              slow_q;
  logic [JUMP_W-1:0] jump_q, jump_d;
  logic              slow_set;

  // Named internal events, brought out for the checker.
  logic      tx_fire;
  logic      erase_fire;
  logic      fill_step;
  logic      load_step;
  logic      load_active;
  logic      at_last;
  cmd_kind_t cmd_kind;

  boot_cmd_decode #(.SLOW_CODE(SLOW_CODE)) u_dec (
    .enable  (state_q == ST_CMD),
    .rx_break(rx_break),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .kind    (cmd_kind)
  );

  boot_addr_ctr #(.DEPTH(RAM_DEPTH)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (ram_we),
    .addr   (ram_addr),
    .at_last(at_last)
  );

  assign fill_step   = (state_q == ST_SEC_FILL);
  assign load_step   = (state_q == ST_LOAD) && rx_valid;
  assign load_active = (state_q == ST_LOAD) || (state_q == ST_ECHO);

  assign tx_valid  = (state_q == ST_SEC_TX) || (state_q == ST_ANNOUNCE) || (state_q == ST_ECHO);
  assign tx_break  = (state_q == ST_ANNOUNCE);
  assign tx_data   = (state_q == ST_ECHO)     ? echo_q :
                     (state_q == ST_ANNOUNCE) ? '0     : CH_SECURE;
  assign tx_fire   = tx_valid && tx_ready;

  assign erase_req  = (state_q == ST_SEC_ERASE) || (state_q == ST_SEC_CFG);
  assign erase_sel  = (state_q == ST_SEC_CFG);
  assign erase_fire = erase_req && erase_done;

  assign ram_we    = fill_step || load_step;
  assign ram_wdata = fill_step ? CH_FILL : rx_data;

  assign done      = (state_q == ST_JUMP);
  assign jump_addr = jump_q;
  assign rate_slow = slow_q;

  always_comb begin
    state_d  = state_q;
    jump_d   = jump_q;
    slow_set = 1'b0;
    unique case (state_q)
      ST_START:     state_d = sec_bit ? ST_SEC_TX : ST_ANNOUNCE;
      ST_SEC_TX:    if (tx_fire) state_d = ST_SEC_ERASE;
      ST_SEC_ERASE: if (erase_fire) state_d = erase_ok ? ST_SEC_FILL : ST_SEC_TX;
      ST_SEC_FILL:  if (at_last) state_d = ST_SEC_CFG;
      ST_SEC_CFG:   if (erase_fire) state_d = ST_ANNOUNCE;
      ST_ANNOUNCE:  if (tx_fire) state_d = ST_CMD;
      ST_CMD: begin
        unique case (cmd_kind)
          CMD_LOAD_FAST: state_d = ST_LOAD;
          CMD_LOAD_SLOW: begin state_d = ST_LOAD; slow_set = 1'b1; end
          CMD_RUN_RAM:   begin state_d = ST_JUMP; jump_d = RAM_BASE; end
          CMD_RUN_EE:    begin state_d = ST_JUMP; jump_d = EE_BASE; end
          default:       state_d = ST_CMD;
        endcase
      end
      ST_LOAD:      if (load_step) state_d = ST_ECHO;
      ST_ECHO: begin
        if (tx_fire) begin
          if (last_q) begin state_d = ST_JUMP; jump_d = RAM_BASE; end
          else        state_d = ST_LOAD;
        end
      end
      ST_JUMP:      state_d = ST_HALT;
      default:      state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_START;
      echo_q  <= '0;
      last_q  <= 1'b0;
      slow_q  <= 1'b0;
      jump_q  <= '0;
    end else begin
      state_q <= state_d;
      jump_q  <= jump_d;
      if (slow_set) slow_q <= 1'b1;
      if (load_step) begin
        echo_q <= rx_data;
        last_q <= at_last;
      end
    end
  end

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int                JUMP_W   = 16,
  parameter logic [JUMP_W-1:0] RAM_BASE = 16'h0000,
  parameter logic [JUMP_W-1:0] EE_BASE  = 16'hB600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_break,
  input logic              erase_req,
  input logic              erase_done,
  input logic              erase_sel,
  input logic              ram_we,
  input logic              done,
  input logic [JUMP_W-1:0] jump_addr,
  input logic              rate_slow,
  input logic              load_active
);

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_break));

  assert_erase_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && !erase_done |=> erase_req && $stable(erase_sel));

  assert_no_tx_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && tx_valid));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (jump_addr == RAM_BASE || jump_addr == EE_BASE));

  assert_slow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(rate_slow));

  assert_slow_enters_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_slow) |-> load_active);

endmodule

bind boot_seq boot_seq_chk #(
  .JUMP_W  (JUMP_W),
  .RAM_BASE(RAM_BASE),
  .EE_BASE (EE_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_break   (tx_break),
  .erase_req  (erase_req),
  .erase_done (erase_done),
  .erase_sel  (erase_sel),
  .ram_we     (ram_we),
  .done       (done),
  .jump_addr  (jump_addr),
  .rate_slow  (rate_slow),
  .load_active(load_active)
);

// File: tb/tb_boot_seq.sv
module tb_boot_seq;
  localparam int CLK_P = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic sec_bit = 0, rx_valid = 0, rx_break = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic erase_done = 0, erase_ok = 0;
  logic tx_valid, tx_break, rate_slow, erase_req, erase_sel, ram_we, done;
  logic [7:0] tx_data, ram_addr, ram_wdata;
  logic [15:0] jump_addr;

  boot_seq dut (
    .clk(clk), .rst_n(rst_n), .sec_bit(sec_bit), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_break(tx_break), .rate_slow(rate_slow), .erase_done(erase_done), .erase_ok(erase_ok),
    .erase_req(erase_req), .erase_sel(erase_sel), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .done(done), .jump_addr(jump_addr)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int tx_n, wr_n, addr_err, done_n, ee_n, cfg_n, fail_left, ew;
  logic [8:0] tx_log [0:599];
  logic [7:0] mem [0:255];
  logic [15:0] last_jump;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Responders driven away from the active edge; monitor just before the edge.
  always @(negedge clk) begin
    tx_ready = ~tx_ready;
    if (erase_done) erase_done = 0;
    else if (erase_req && rst_n) begin
      ew++;
      if (ew == 3) begin
        ew = 0;
        erase_done = 1;
        if (erase_sel) begin cfg_n++; erase_ok = 1; end
        else begin
          ee_n++;
          erase_ok = (fail_left == 0);
          if (fail_left > 0) fail_left--;
        end
      end
    end
    #(CLK_P/2 - 1);
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        if (tx_n < 600) tx_log[tx_n] = {tx_break, tx_data};
        tx_n++;
      end
      if (ram_we) begin
        if (ram_addr != 8'(wr_n)) addr_err++;
        mem[ram_addr] = ram_wdata;
        wr_n++;
      end
      if (done) begin done_n++; last_jump = jump_addr; end
    end
  end

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic do_reset(input logic sec, input int fails);
    @(negedge clk);
    rst_n = 0; sec_bit = sec; rx_valid = 0; rx_break = 0;
    tx_n = 0; wr_n = 0; addr_err = 0; done_n = 0; ee_n = 0; cfg_n = 0;
    fail_left = fails; ew = 0; last_jump = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(input logic [7:0] b, input logic brk);
    @(negedge clk);
    rx_data = b; rx_valid = !brk; rx_break = brk;
    @(negedge clk);
    rx_valid = 0; rx_break = 0;
  endtask

  task automatic wait_tx(input int target);
    int t = 0;
    while (tx_n < target && t < 4000) begin @(negedge clk); t++; end
  endtask

  // sec, fails[3:0], cmd, brk, pre, jump, dl, slow
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 4'd0, 8'hFF, 1'b0, 8'h00, 16'h0000, 1'b1, 1'b0},
    {1'b1, 4'd2, 8'h55, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0},
    {1'b0, 4'd0, 8'h00, 1'b0, 8'h3C, 16'hB600, 1'b0, 1'b0},
    {1'b0, 4'd0, 8'h00, 1'b1, 8'h00, 16'hB600, 1'b0, 1'b0},
    {1'b1, 4'd0, 8'hE0, 1'b0, 8'h00, 16'h0000, 1'b1, 1'b1},
    {1'b0, 4'd0, 8'h55, 1'b0, 8'hA5, 16'h0000, 1'b0, 1'b0}
  };

  initial begin
    // R1: outputs idle while reset is held
    do_reset(1'b1, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(!tx_valid && !erase_req && !ram_we && !done && !rate_slow, "R1", "idle in reset",
        {tx_valid, erase_req, ram_we, done, rate_slow}, 0);

    for (int v = 0; v < NV; v++) begin
      logic sec, brk, dl, slow;
      logic [3:0] fails;
      logic [7:0] cmd, pre;
      logic [15:0] ej;
      int pre_tx, base, exp_tx, ok_cnt;
      {sec, fails, cmd, brk, pre, ej, dl, slow} = VEC[v];
      do_reset(sec, fails);
      pre_tx = sec ? fails + 1 : 0;
      wait_tx(pre_tx + 1);
      // R2 secure preamble and R4 announce break
      ok_cnt = 0;
      for (int i = 0; i < pre_tx; i++) if (tx_log[i] == 9'h0FF) ok_cnt++;
      chk(ok_cnt == pre_tx, "R2", "secure FF bytes", ok_cnt, pre_tx);
      chk(ee_n == pre_tx, "R2", "array erase count", ee_n, pre_tx);
      chk(cfg_n == (sec ? 1 : 0), "R3", "config erase count", cfg_n, sec);
      chk(tx_log[pre_tx][8] == 1'b1, "R4", "break after security", tx_log[pre_tx], 9'h100);
      if (sec) begin
        ok_cnt = 0;
        for (int i = 0; i < 256; i++) if (mem[i] == 8'hFF) ok_cnt++;
        chk(wr_n == 256 && ok_cnt == 256 && addr_err == 0, "R3", "fill FF in order", ok_cnt, 256);
      end
      @(negedge clk);
      if (pre != 8'h00) begin
        base = tx_n;
        send(pre, 1'b0);
        repeat (6) @(negedge clk);
        chk(tx_n == base && done_n == 0 && wr_n == (sec ? 256 : 0), "R10",
            "ignored first byte", tx_n - base + done_n, 0);
      end
      base = tx_n;
      send(cmd, brk);
      if (dl) begin
        for (int k = 0; k < 256; k++) begin
          send(pat(k), 1'b0);
          wait_tx(base + k + 1);
        end
      end
      for (int t = 0; t < 50 && done_n == 0; t++) @(negedge clk);
      repeat (5) @(negedge clk);
      exp_tx = pre_tx + 1 + (dl ? 256 : 0);
      chk(tx_n == exp_tx, dl ? "R5" : "R7", "transmit count", tx_n, exp_tx);
      chk(done_n == 1, "R12", "done pulses", done_n, 1);
      chk(last_jump == ej, brk ? "R8" : (dl ? "R6" : "R7"), "jump target", last_jump, ej);
      chk(rate_slow == slow, "R9", "rate select", rate_slow, slow);
      if (dl) begin
        ok_cnt = 0;
        for (int k = 0; k < 256; k++)
          if (mem[k] == pat(k) && tx_log[pre_tx + 1 + k] == {1'b0, pat(k)}) ok_cnt++;
        chk(ok_cnt == 256, "R6", "download image and echoes", ok_cnt, 256);
        chk(addr_err == 0 && wr_n == (sec ? 512 : 256), "R5", "write count, lead char not stored",
            wr_n, sec ? 512 : 256);
      end else begin
        chk(wr_n == (sec ? 256 : 0), "R7", "no download writes", wr_n, sec ? 256 : 0);
      end
    end

    // R8: break and byte together -> break wins
    do_reset(1'b0, 0);
    wait_tx(1);
    @(negedge clk);
    @(negedge clk);
    rx_data = 8'hFF; rx_valid = 1; rx_break = 1;
    @(negedge clk);
    rx_valid = 0; rx_break = 0;
    repeat (5) @(negedge clk);
    chk(done_n == 1 && last_jump == 16'hB600, "R8", "break priority", last_jump, 16'hB600);
    chk(wr_n == 0 && tx_n == 1, "R8", "no download on break", wr_n + tx_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule